// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block watches the write cycles that a host issues to a parallel NOR flash and recognises the multi-cycle command sequences of the classic two-cycle-unlock command style. From those sequences it raises single-cycle strobes for programming, sector erase, chip erase, erase suspend and erase resume. It also tracks the identification mode, the query-table mode and the unlock-bypass mode. For every read it tells the surrounding flash model which source answers it: the array, an ID word, a constant zero, the query table or the status byte.

The array, the erase timers and the status-bit logic sit outside. The erase timer reports back through two inputs. `erase_window_open` says that more sector-erase commands may still be queued. `op_done` says that the running erase has finished. An erase-map outside the block flags whether the addressed sector is one that is pending erase. The device width (1, 2 or 4 bytes) scales byte addresses into command addresses. Command addresses used for unlock matching keep 11 bits. Read indices keep the low 8 bits of the byte address before scaling.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset the decoder is in read mode. All strobes are low, bypass and suspend are clear, and `rd_sel` is 0 (array).
- R2: The command address is the byte address shifted right by 0, 1 or 2 for `dev_width` 0, 1 or 2 and above, then cut to 11 bits. Both unlock addresses are cut to 11 bits before the compare. The read index is the low 8 bits of `rd_addr`, scaled by the same shift.
- R3: An unlock needs 0xAA at unlock address 0 followed by 0x55 at unlock address 1. Any other write in either of those cycles returns the decoder to read mode.
- R4: The third cycle must be at unlock address 0, unless bypass is on. Data 0x80 starts erase, 0x90 enters identification mode, 0xA0 starts program and 0x20 turns bypass on. Any other value, or a wrong address, returns the decoder to read mode.
- R5: The data cycle after 0xA0 raises `prog_stb` for one cycle, one clock after the write. This happens even when the data is 0xF0. The decoder then returns to read mode, or to the command cycle when bypass is on.
- R6: After 0x80 and a second AA/55 pair, 0x10 at unlock address 0 raises `chip_erase_stb`. 0x10 at any other address returns to read mode. During a chip erase, reads select status (`rd_sel`=4) and every write is ignored, 0xF0 included, until `op_done`.
- R7: 0x30 in the sixth cycle, at any address, raises `sect_erase_stb` and enters the sector-erase state, where reads select status. While `erase_window_open` is high, a further 0x30 raises another strobe, and any other write except 0xB0 returns to read mode. While the window is closed, such writes are ignored.
- R8: 0xB0 during a sector erase raises `suspend_stb`, sets `erase_suspended` and returns to read mode. 0xB0 in read mode with no suspended erase is ignored. While suspended, 0x30 in read mode raises `resume_stb` and returns to the sector-erase state, and a new erase sequence is refused at its sixth cycle.
- R9: While suspended, a program data cycle that targets a sector flagged by `wr_sect_erasing` raises no strobe.
- R10: 0x20 in the command cycle sets `bypass_on` and keeps the decoder in the command cycle. Later commands need no unlock pair and no address match. After a bypass program the decoder waits in the command cycle again. 0x00 written in identification mode clears bypass.
- R11: 0x98 at command address 0x55 enters query mode from read mode, and any later write leaves it for read mode. From identification mode, the same write enters a query sub-mode that 0xF0 leaves for identification mode.
- R12: In identification mode, read index 0 or 1 selects ID word 0 or 1 (`rd_sel`=1, `rd_id_num` = index) and index 2 selects zero (`rd_sel`=2). Index 0x0E or 0x0F selects ID word 2 or 3, or the array when that word's low byte is 0xFF. All other indices select the array. Query modes select `rd_sel`=3 with `rd_index` as the table index.
- R13: While an erase is suspended, a read in a read-like mode of a sector flagged by `rd_sect_erasing` selects status. 0xF0 outside program, chip erase and sector erase returns to read mode and clears bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_width | input | 2 | Device width code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| unlock_addr0 | input | 16 | First unlock command address (11 bits used) |
| unlock_addr1 | input | 16 | Second unlock command address (11 bits used) |
| wr_en | input | 1 | Bus write valid |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Command/data byte of the write |
| wr_sect_erasing | input | 1 | Written sector is pending erase |
| rd_addr | input | ADDR_W | Byte address of the current read |
| rd_sect_erasing | input | 1 | Read sector is pending erase |
| erase_window_open | input | 1 | Further sector-erase commands may still be queued |
| op_done | input | 1 | Running erase has finished |
| prog_stb | output | 1 | Program strobe |
| sect_erase_stb | output | 1 | Sector-erase strobe (address on the bus of the same write) |
| chip_erase_stb | output | 1 | Chip-erase strobe |
| suspend_stb | output | 1 | Erase-suspend strobe |
| resume_stb | output | 1 | Erase-resume strobe |
| bypass_on | output | 1 | Unlock bypass active |
| erase_suspended | output | 1 | A sector erase is suspended |
| rd_sel | output | 3 | Read source: 0 array, 1 ID word, 2 zero, 3 query table, 4 status |
| rd_id_num | output | 2 | ID word number when `rd_sel` is 1 |
| rd_index | output | 8 | Scaled read index, used by the query table |

## Verification
All strobes and mode changes are registered. A write that is sampled at a rising edge shows its strobe, and its new read selection, in the cycle that follows that edge. The read selection is combinational from the current mode and `rd_addr`, so it is due in the same cycle as an address change. The bench drives each write on a falling edge and holds it through one rising edge. It samples strobes and `rd_sel` on the next falling edge, exactly one register stage after the write. `op_done` uses the same one-cycle timing. Modes are seen from the ports by placing a read at index 0 and checking `rd_sel`.

// File: rtl/nfd_pkg.sv
package nfd_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_CMD,
        ST_ERA_U0,
        ST_ERA_U1,
        ST_ERA_SEL,
        ST_PROG,
        ST_ID,
        ST_QRY,
        ST_QRY_ID,
        ST_CHIP,
        ST_SECT
    } mode_e;

    localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
    localparam logic [7:0] CMD_ERASE    = 8'h80;
    localparam logic [7:0] CMD_IDENT    = 8'h90;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_BYPASS   = 8'h20;
    localparam logic [7:0] CMD_CHIP     = 8'h10;
    localparam logic [7:0] CMD_SECTOR   = 8'h30;
    localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
    localparam logic [7:0] CMD_QUERY    = 8'h98;
    localparam logic [7:0] CMD_RESET    = 8'hF0;
    localparam logic [7:0] CMD_BYP_EXIT = 8'h00;

    localparam logic [10:0] QUERY_CADDR = 11'h055;

    localparam logic [2:0] RS_ARRAY  = 3'd0;
    localparam logic [2:0] RS_ID     = 3'd1;
    localparam logic [2:0] RS_ZERO   = 3'd2;
    localparam logic [2:0] RS_QUERY  = 3'd3;
    localparam logic [2:0] RS_STATUS = 3'd4;

    typedef struct packed {
        mode_e mode;
        logic  bypass;
        logic  susp;
        logic  prog_stb;
        logic  sect_stb;
        logic  chip_stb;
        logic  spd_stb;
        logic  rsm_stb;
    } seq_s;

endpackage

// File: rtl/nfd_addr_scale.sv
module nfd_addr_scale #(
    parameter int IN_W  = 24,
    parameter int PRE_W = 24,
    parameter int OUT_W = 11
) (
    input  logic [IN_W-1:0]  byte_addr,
    input  logic [1:0]       dev_width,
    output logic [OUT_W-1:0] cmd_addr
);

    logic [IN_W-1:0] pre_d;
    logic [IN_W-1:0] shifted_d;

    generate
        if (PRE_W < IN_W) begin : g_premask
            assign pre_d = {{(IN_W-PRE_W){1'b0}}, byte_addr[PRE_W-1:0]};
        end else begin : g_full
            assign pre_d = byte_addr;
        end
    endgenerate

    always_comb begin
        case (dev_width)
            2'b00:   shifted_d = pre_d;
            2'b01:   shifted_d = pre_d >> 1;
            default: shifted_d = pre_d >> 2;
        endcase
    end

    assign cmd_addr = shifted_d[OUT_W-1:0];

endmodule

// File: rtl/nfd_seq_fsm.sv
module nfd_seq_fsm
    import nfd_pkg::*;
#(
    parameter int CMD_AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic [CMD_AW-1:0] wr_caddr,
    input  logic [CMD_AW-1:0] unl0,
    input  logic [CMD_AW-1:0] unl1,
    input  logic              wr_sect_erasing,
    input  logic              erase_window_open,
    input  logic              op_done,
    output mode_e             mode,
    output logic              bypass,
    output logic              susp,
    output logic              prog_stb,
    output logic              sect_stb,
    output logic              chip_stb,
    output logic              spd_stb,
    output logic              rsm_stb
);

    seq_s q, d;

    logic hit_u0, hit_u1, hit_qry;
    assign hit_u0  = (wr_caddr == unl0);
    assign hit_u1  = (wr_caddr == unl1);
    assign hit_qry = (wr_caddr == QUERY_CADDR[CMD_AW-1:0]);

    always_comb begin
        d          = q;
        d.prog_stb = 1'b0;
        d.sect_stb = 1'b0;
        d.chip_stb = 1'b0;
        d.spd_stb  = 1'b0;
        d.rsm_stb  = 1'b0;
        if (wr_en) begin
            if (wr_data == CMD_RESET && q.mode != ST_PROG &&
                q.mode != ST_CHIP && q.mode != ST_SECT) begin
                if (q.mode == ST_QRY_ID) begin
                    d.mode = ST_ID;
                end else begin
                    d.mode   = ST_READ;
                    d.bypass = 1'b0;
                end
            end else begin
                case (q.mode)
                    ST_READ: begin
                        if (hit_qry && wr_data == CMD_QUERY) begin
                            d.mode = ST_QRY;
                        end else if (wr_data == CMD_SECTOR) begin
                            if (q.susp) begin
                                d.mode    = ST_SECT;
                                d.susp    = 1'b0;
                                d.rsm_stb = 1'b1;
                            end else begin
                                d.mode   = ST_READ;
                                d.bypass = 1'b0;
                            end
                        end else if (wr_data == CMD_SUSPEND) begin
                            d.mode = ST_READ;
                        end else if (hit_u0 && wr_data == CMD_UNLOCK_A) begin
                            d.mode = ST_UNL1;
                        end else begin
                            d.mode   = ST_READ;
                            d.bypass = 1'b0;
                        end
                    end
                    ST_UNL1: begin
                        if (hit_u1 && wr_data == CMD_UNLOCK_B) begin
                            d.mode = ST_CMD;
                        end else begin
                            d.mode   = ST_READ;
                            d.bypass = 1'b0;
                        end
                    end
                    ST_CMD: begin
                        if (!q.bypass && !hit_u0) begin
                            d.mode   = ST_READ;
                            d.bypass = 1'b0;
                        end else begin
                            case (wr_data)
                                CMD_BYPASS:  d.bypass = 1'b1;
                                CMD_ERASE:   d.mode   = ST_ERA_U0;
                                CMD_IDENT:   d.mode   = ST_ID;
                                CMD_PROGRAM: d.mode   = ST_PROG;
                                default: begin
                                    d.mode   = ST_READ;
                                    d.bypass = 1'b0;
                                end
                            endcase
                        end
                    end
                    ST_ERA_U0: begin
                        if (hit_u0 && wr_data == CMD_UNLOCK_A) begin
                            d.mode = ST_ERA_U1;
                        end else begin
                            d.mode   = ST_READ;
                            d.bypass = 1'b0;
                        end
                    end
                    ST_ERA_U1: begin
                        if (hit_u1 && wr_data == CMD_UNLOCK_B) begin
                            d.mode = ST_ERA_SEL;
                        end else begin
                            d.mode   = ST_READ;
                            d.bypass = 1'b0;
                        end
                    end
                    ST_ERA_SEL: begin
                        if (!q.susp && wr_data == CMD_CHIP && hit_u0) begin
                            d.mode     = ST_CHIP;
                            d.chip_stb = 1'b1;
                        end else if (!q.susp && wr_data == CMD_SECTOR) begin
                            d.mode     = ST_SECT;
                            d.sect_stb = 1'b1;
                        end else begin
                            d.mode   = ST_READ;
                            d.bypass = 1'b0;
                        end
                    end
                    ST_PROG: begin
                        if (q.susp && wr_sect_erasing) begin
                            if (q.bypass) begin
                                d.mode = ST_CMD;
                            end else begin
                                d.mode = ST_READ;
                            end
                        end else begin
                            d.prog_stb = 1'b1;
                            d.mode     = q.bypass ? ST_CMD : ST_READ;
                        end
                    end
                    ST_ID: begin
                        if (q.bypass && wr_data == CMD_BYP_EXIT) begin
                            d.mode   = ST_READ;
                            d.bypass = 1'b0;
                        end else if (hit_qry && wr_data == CMD_QUERY) begin
                            d.mode = ST_QRY_ID;
                        end else begin
                            d.mode   = ST_READ;
                            d.bypass = 1'b0;
                        end
                    end
                    ST_CHIP: begin
                        d.mode = ST_CHIP;
                    end
                    ST_SECT: begin
                        if (wr_data == CMD_SUSPEND) begin
                            d.mode    = ST_READ;
                            d.susp    = 1'b1;
                            d.spd_stb = 1'b1;
                        end else if (erase_window_open) begin
                            if (wr_data == CMD_SECTOR) begin
                                d.sect_stb = 1'b1;
                            end else begin
                                d.mode   = ST_READ;
                                d.bypass = 1'b0;
                            end
                        end
                    end
                    default: begin
                        d.mode   = ST_READ;
                        d.bypass = 1'b0;
                    end
                endcase
            end
        end else if (op_done && (q.mode == ST_CHIP || q.mode == ST_SECT)) begin
            d.mode = q.bypass ? ST_CMD : ST_READ;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{mode: ST_READ, default: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign mode     = q.mode;
    assign bypass   = q.bypass;
    assign susp     = q.susp;
    assign prog_stb = q.prog_stb;
    assign sect_stb = q.sect_stb;
    assign chip_stb = q.chip_stb;
    assign spd_stb  = q.spd_stb;
    assign rsm_stb  = q.rsm_stb;

    AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.prog_stb, q.sect_stb, q.chip_stb, q.spd_stb, q.rsm_stb})); // R5
    AST_PROG_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        q.prog_stb |-> (q.mode == ST_READ || q.mode == ST_CMD)); // R5
    AST_CHIP_FROM_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        q.chip_stb |-> $past(q.mode) == ST_ERA_SEL); // R6
    AST_CHIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == ST_CHIP && !op_done) |=> q.mode == ST_CHIP); // R6
    AST_QRY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == ST_QRY && wr_en) |=> q.mode == ST_READ); // R11
    AST_SUSPEND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.spd_stb |-> (q.susp && q.mode == ST_READ)); // R8

endmodule

// File: rtl/nfd_read_sel.sv
module nfd_read_sel
    import nfd_pkg::*;
#(
    parameter int          RD_IW   = 8,
    parameter logic [15:0] ID_WORD2 = 16'h2201,
    parameter logic [15:0] ID_WORD3 = 16'h00FF
) (
    input  mode_e            mode,
    input  logic             susp,
    input  logic             rd_sect_erasing,
    input  logic [RD_IW-1:0] rd_idx,
    output logic [2:0]       rd_sel,
    output logic [1:0]       rd_id_num
);

    localparam logic [RD_IW-1:0] IDX_ID0  = RD_IW'(8'h00);
    localparam logic [RD_IW-1:0] IDX_ID1  = RD_IW'(8'h01);
    localparam logic [RD_IW-1:0] IDX_PROT = RD_IW'(8'h02);
    localparam logic [RD_IW-1:0] IDX_ID2  = RD_IW'(8'h0E);
    localparam logic [RD_IW-1:0] IDX_ID3  = RD_IW'(8'h0F);
    localparam logic ID2_VALID = (ID_WORD2[7:0] != 8'hFF);
    localparam logic ID3_VALID = (ID_WORD3[7:0] != 8'hFF);

    always_comb begin
        rd_sel    = RS_ARRAY;
        rd_id_num = 2'd0;
        case (mode)
            ST_ID: begin
                if (rd_idx == IDX_ID0) begin
                    rd_sel = RS_ID;
                end else if (rd_idx == IDX_ID1) begin
                    rd_sel    = RS_ID;
                    rd_id_num = 2'd1;
                end else if (rd_idx == IDX_PROT) begin
                    rd_sel = RS_ZERO;
                end else if (rd_idx == IDX_ID2 && ID2_VALID) begin
                    rd_sel    = RS_ID;
                    rd_id_num = 2'd2;
                end else if (rd_idx == IDX_ID3 && ID3_VALID) begin
                    rd_sel    = RS_ID;
                    rd_id_num = 2'd3;
                end
            end
            ST_QRY, ST_QRY_ID:        rd_sel = RS_QUERY;
            ST_PROG, ST_CHIP, ST_SECT: rd_sel = RS_STATUS;
            default: begin
                if (susp && rd_sect_erasing) begin
                    rd_sel = RS_STATUS;
                end
            end
        endcase
    end

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
    import nfd_pkg::*;
#(
    parameter int          ADDR_W   = 24,
    parameter int          CMD_AW   = 11,
    parameter int          RD_IW    = 8,
    parameter logic [15:0] ID_WORD2 = 16'h2201,
    parameter logic [15:0] ID_WORD3 = 16'h00FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        dev_width,
    input  logic [15:0]       unlock_addr0,
    input  logic [15:0]       unlock_addr1,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              wr_sect_erasing,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_sect_erasing,
    input  logic              erase_window_open,
    input  logic              op_done,
    output logic              prog_stb,
    output logic              sect_erase_stb,
    output logic              chip_erase_stb,
    output logic              suspend_stb,
    output logic              resume_stb,
    output logic              bypass_on,
    output logic              erase_suspended,
    output logic [2:0]        rd_sel,
    output logic [1:0]        rd_id_num,
    output logic [RD_IW-1:0]  rd_index
);

    logic [CMD_AW-1:0] wr_caddr;
    logic [CMD_AW-1:0] unl0_m, unl1_m;
    mode_e             mode;

    assign unl0_m = unlock_addr0[CMD_AW-1:0];
    assign unl1_m = unlock_addr1[CMD_AW-1:0];

    nfd_addr_scale #(.IN_W(ADDR_W), .PRE_W(ADDR_W), .OUT_W(CMD_AW)) u_wr_scale (
        .byte_addr (wr_addr),
        .dev_width (dev_width),
        .cmd_addr  (wr_caddr)
    );

    nfd_addr_scale #(.IN_W(ADDR_W), .PRE_W(RD_IW), .OUT_W(RD_IW)) u_rd_scale (
        .byte_addr (rd_addr),
        .dev_width (dev_width),
        .cmd_addr  (rd_index)
    );

    nfd_seq_fsm #(.CMD_AW(CMD_AW)) u_fsm (
        .clk               (clk),
        .rst_n             (rst_n),
        .wr_en             (wr_en),
        .wr_data           (wr_data),
        .wr_caddr          (wr_caddr),
        .unl0              (unl0_m),
        .unl1              (unl1_m),
        .wr_sect_erasing   (wr_sect_erasing),
        .erase_window_open (erase_window_open),
        .op_done           (op_done),
        .mode              (mode),
        .bypass            (bypass_on),
        .susp              (erase_suspended),
        .prog_stb          (prog_stb),
        .sect_stb          (sect_erase_stb),
        .chip_stb          (chip_erase_stb),
        .spd_stb           (suspend_stb),
        .rsm_stb           (resume_stb)
    );

    nfd_read_sel #(.RD_IW(RD_IW), .ID_WORD2(ID_WORD2), .ID_WORD3(ID_WORD3)) u_rsel (
        .mode            (mode),
        .susp            (erase_suspended),
        .rd_sect_erasing (rd_sect_erasing),
        .rd_idx          (rd_index),
        .rd_sel          (rd_sel),
        .rd_id_num       (rd_id_num)
    );

    AST_CHIP_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        chip_erase_stb |-> rd_sel == RS_STATUS); // R6
    AST_RESUME_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        resume_stb |-> (rd_sel == RS_STATUS && !erase_suspended)); // R8

endmodule

// File: tb/tb_nor_cmd_decoder.sv
module tb_nor_cmd_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;

    localparam logic [4:0] S_NONE = 5'b00000;
    localparam logic [4:0] S_PROG = 5'b10000;
    localparam logic [4:0] S_SECT = 5'b01000;
    localparam logic [4:0] S_CHIP = 5'b00100;
    localparam logic [4:0] S_SPD  = 5'b00010;
    localparam logic [4:0] S_RSM  = 5'b00001;

    logic clk = 0;
    logic rst_n = 0;
    logic [1:0] dev_width = 2'd0;
    logic [15:0] unlock_addr0 = 16'h0555;
    logic [15:0] unlock_addr1 = 16'h02AA;
    logic wr_en = 0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic wr_sect_erasing = 0;
    logic [AW-1:0] rd_addr = '0;
    logic rd_sect_erasing = 0;
    logic erase_window_open = 0;
    logic op_done = 0;
    logic prog_stb, sect_erase_stb, chip_erase_stb, suspend_stb, resume_stb;
    logic bypass_on, erase_suspended;
    logic [2:0] rd_sel;
    logic [1:0] rd_id_num;
    logic [7:0] rd_index;

    int n_checks = 0;
    int n_errors = 0;
    logic [4:0] last_stb;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .dev_width(dev_width),
        .unlock_addr0(unlock_addr0), .unlock_addr1(unlock_addr1),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_sect_erasing(wr_sect_erasing), .rd_addr(rd_addr),
        .rd_sect_erasing(rd_sect_erasing), .erase_window_open(erase_window_open),
        .op_done(op_done), .prog_stb(prog_stb), .sect_erase_stb(sect_erase_stb),
        .chip_erase_stb(chip_erase_stb), .suspend_stb(suspend_stb),
        .resume_stb(resume_stb), .bypass_on(bypass_on),
        .erase_suspended(erase_suspended), .rd_sel(rd_sel),
        .rd_id_num(rd_id_num), .rd_index(rd_index)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual !== expected) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] dat);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = dat;
        @(negedge clk);
        wr_en = 0;
        last_stb = {prog_stb, sect_erase_stb, chip_erase_stb, suspend_stb, resume_stb};
    endtask

    task automatic pulse_done();
        @(negedge clk); op_done = 1;
        @(negedge clk); op_done = 0;
    endtask

    task automatic unlock();
        wr(24'h555, 8'hAA);
        wr(24'h2AA, 8'h55);
    endtask

    task automatic erase_prefix();
        unlock();
        wr(24'h555, 8'h80);
        unlock();
    endtask

    task automatic t_reset();
        rd_addr = 0; #1;
        check("R1 rd_sel", rd_sel, 0);
        check("R1 strobes", {prog_stb, sect_erase_stb, chip_erase_stb, suspend_stb, resume_stb}, 0);
        check("R1 bypass/suspend", {bypass_on, erase_suspended}, 0);
    endtask

    task automatic t_program();
        unlock(); wr(24'h555, 8'hA0);
        check("R5 status during program", rd_sel, 4);
        wr(24'h1234, 8'hF0);
        check("R5 prog strobe with F0 data", last_stb, S_PROG);
        check("R5 back to read", rd_sel, 0);
    endtask

    task automatic t_unlock_bad();
        wr(24'h555, 8'hAA); wr(24'h2AB, 8'h55);
        wr(24'h555, 8'h90);
        check("R3 wrong unlock1 address", rd_sel, 0);
        wr(24'h555, 8'hAB); wr(24'h2AA, 8'h55); wr(24'h555, 8'h90);
        check("R3 wrong unlock0 data", rd_sel, 0);
    endtask

    task automatic t_cmd_bad();
        unlock(); wr(24'h555, 8'h55);
        check("R4 unknown command", rd_sel, 0);
        unlock(); wr(24'h556, 8'h90);
        check("R4 wrong command address", rd_sel, 0);
        unlock(); wr(24'h555, 8'h90);
        check("R4 identification entry", rd_sel, 1);
        wr(24'h0, 8'hF0);
        check("R13 F0 leaves identification", rd_sel, 0);
    endtask

    task automatic t_width();
        dev_width = 2'd1; unlock_addr0 = 16'hF555;
        wr(24'hAAA, 8'hAA); wr(24'h554, 8'h55); wr(24'h100AAA, 8'h90);
        rd_addr = 0; #1;
        check("R2 scaled and masked unlock", rd_sel, 1);
        rd_addr = 24'h02; #1;
        check("R2 scaled read index", rd_index, 1);
        check("R2 index 1 selects ID1", rd_id_num, 1);
        wr(24'h0, 8'hF0);
        dev_width = 2'd2; rd_addr = 24'h3C; #1;
        check("R2 width 4 read index", rd_index, 8'h0F);
        dev_width = 2'd0; unlock_addr0 = 16'h0555; rd_addr = 0;
    endtask

    task automatic t_ident();
        unlock(); wr(24'h555, 8'h90);
        rd_addr = 24'h01; #1;
        check("R12 idx1 sel", rd_sel, 1); check("R12 idx1 num", rd_id_num, 1);
        rd_addr = 24'h02; #1; check("R12 idx2 zero", rd_sel, 2);
        rd_addr = 24'h10E; #1;
        check("R12 idx E sel", rd_sel, 1); check("R12 idx E num", rd_id_num, 2);
        rd_addr = 24'h0F; #1; check("R12 idx F FF falls to array", rd_sel, 0);
        rd_addr = 24'h03; #1; check("R12 other idx array", rd_sel, 0);
        rd_addr = 0;
        wr(24'h0, 8'hF0);
    endtask

    task automatic t_query();
        wr(24'h055, 8'h98);
        rd_addr = 24'h10; #1;
        check("R11 query select", rd_sel, 3); check("R11 query index", rd_index, 8'h10);
        rd_addr = 0;
        wr(24'h0, 8'h12);
        check("R11 write leaves query", rd_sel, 0);
        unlock(); wr(24'h555, 8'h90); wr(24'h055, 8'h98);
        check("R11 query from identification", rd_sel, 3);
        wr(24'h0, 8'hF0);
        check("R11 F0 back to identification", rd_sel, 1);
        wr(24'h0, 8'hF0);
        check("R11 F0 then read", rd_sel, 0);
    endtask

    task automatic t_chip();
        erase_prefix(); wr(24'h123, 8'h10);
        check("R6 chip erase wrong address no strobe", last_stb, S_NONE);
        check("R6 chip erase wrong address read", rd_sel, 0);
        erase_prefix(); wr(24'h555, 8'h10);
        check("R6 chip strobe", last_stb, S_CHIP);
        check("R6 chip status", rd_sel, 4);
        wr(24'h0, 8'hF0);
        check("R6 F0 ignored in chip erase", rd_sel, 4);
        pulse_done();
        check("R6 done returns read", rd_sel, 0);
    endtask

    task automatic t_sector();
        erase_prefix(); wr(24'h4000, 8'h30);
        check("R7 sector strobe", last_stb, S_SECT);
        check("R7 sector status", rd_sel, 4);
        erase_window_open = 1;
        wr(24'h8000, 8'h30);
        check("R7 extra sector strobe", last_stb, S_SECT);
        wr(24'h0, 8'h77);
        check("R7 other write in window resets", rd_sel, 0);
        erase_window_open = 0;
        erase_prefix(); wr(24'h4000, 8'h30);
        wr(24'h0, 8'h77);
        check("R7 closed window ignores writes", rd_sel, 4);
        check("R7 closed window no strobe", last_stb, S_NONE);
        pulse_done();
        check("R7 done returns read", rd_sel, 0);
    endtask

    task automatic t_suspend();
        wr(24'h555, 8'hB0);
        check("R8 B0 in read ignored", {last_stb, rd_sel}, 0);
        unlock(); wr(24'h555, 8'h90);
        check("R8 unlock still works after ignored B0", rd_sel, 1);
        wr(24'h0, 8'hF0);
        erase_prefix(); wr(24'h4000, 8'h30);
        wr(24'h0, 8'hB0);
        check("R8 suspend strobe", last_stb, S_SPD);
        check("R8 suspended flag", erase_suspended, 1);
        check("R8 read mode while suspended", rd_sel, 0);
        rd_sect_erasing = 1; #1;
        check("R13 erasing sector reads status", rd_sel, 4);
        rd_sect_erasing = 0;
        wr_sect_erasing = 1;
        unlock(); wr(24'h555, 8'hA0); wr(24'h4004, 8'h00);
        check("R9 program to erasing sector ignored", last_stb, S_NONE);
        wr_sect_erasing = 0;
        unlock(); wr(24'h555, 8'hA0); wr(24'hC000, 8'h00);
        check("R9 program elsewhere allowed", last_stb, S_PROG);
        erase_prefix(); wr(24'h8000, 8'h30);
        check("R8 erase refused while suspended", last_stb, S_NONE);
        wr(24'h0, 8'h30);
        check("R8 resume strobe", last_stb, S_RSM);
        check("R8 resume status", rd_sel, 4);
        check("R8 resume clears suspend", erase_suspended, 0);
        pulse_done();
        check("R8 done after resume", rd_sel, 0);
    endtask

    task automatic t_bypass();
        unlock(); wr(24'h555, 8'h20);
        check("R10 bypass on", bypass_on, 1);
        wr(24'h123, 8'hA0); wr(24'h300, 8'h5A);
        check("R10 bypass program strobe", last_stb, S_PROG);
        check("R10 bypass kept", bypass_on, 1);
        wr(24'h777, 8'hA0); wr(24'h304, 8'h11);
        check("R10 second bypass program", last_stb, S_PROG);
        wr(24'h010, 8'h90);
        check("R10 bypass identification", rd_sel, 1);
        wr(24'h0, 8'h00);
        check("R10 00 exits bypass", bypass_on, 0);
        check("R10 read after exit", rd_sel, 0);
        unlock(); wr(24'h555, 8'h20); wr(24'h0, 8'hF0);
        check("R13 F0 clears bypass", bypass_on, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_program();
        t_unlock_bad();
        t_cmd_bad();
        t_width();
        t_ident();
        t_query();
        t_chip();
        t_sector();
        t_suspend();
        t_bypass();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule